// File: doc/BRIEF.md
# Fuzzy Arithmetic Coprocessor on a Selector Bus

This block sits beside a small microcontroller and takes over the arithmetic and lattice operations that fuzzy inference and defuzzification lean on: unsigned 8-bit multiply, unsigned 8-bit divide, maximum and minimum. The host reaches it through one shared 8-bit data path and a 4-bit selector. A write strobe stores the data byte into the operand slot the selector names. A read strobe returns the result the selector names. Each operation has its own operand slots, so work on one operation does not disturb the others.

Multiply and divide are purely combinational from their operand registers. A result can be read in the cycle after its last operand write. The maximum and minimum units keep their operands in local registers and present their result from a register, which adds one more clock of latency. There is no busy or done flag and no back-pressure: every strobe is accepted in the cycle it is presented. The host must wait out the settling delay before reading, and a read that comes too early returns the previous result.

Top module: `fuzzy_coproc`

## Requirements
- R1: After reset every operand register and every registered result is zero. Product low (sel 2) and high (sel 3) read 0x00, quotient (sel 6) reads 0xFF, remainder (sel 7) reads 0x00, maximum (sel 11) and minimum (sel 15) read 0x00.
- R2: A write strobe with sel 0 stores the first multiplicand and with sel 1 the second. From the cycle after the capturing edge, a read with sel 2 returns bits 7:0 of the unsigned 16-bit product and a read with sel 3 returns bits 15:8.
- R3: A write with sel 4 stores the dividend and with sel 5 the divisor. From the cycle after the capturing edge, a read with sel 6 returns the unsigned integer quotient and a read with sel 7 returns the remainder.
- R4: With a zero divisor, the quotient reads 0xFF and the remainder reads the dividend.
- R5: Writes with sel 9 and 10 store the two maximum operands. The maximum result register loads the larger operand on every clock edge, so a read with sel 11 in the cycle right after the second operand write returns the previous result, and the new maximum is returned one cycle later.
- R6: Writes with sel 13 and 14 store the two minimum operands. The minimum is held in a result register with the same one-cycle lag, and it is read with sel 15.
- R7: A write with sel 8 or 12 changes no readable result, and a read with sel 8 or 12 returns 0x00.
- R8: A write strobe with a read code (2, 3, 6, 7, 11, 15) is ignored. A read strobe with a write code (0, 1, 4, 5, 9, 10, 13, 14) returns 0x00, and a write presented in the same cycle still takes effect.
- R9: The data output is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 4 | Register/result selector code |
| wr_en | input | 1 | Write strobe, captures wdata into the selected slot |
| rd_en | input | 1 | Read strobe, drives the selected result onto rdata |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0x00 when not reading |

## Verification
Two things can fall in the same cycle. The first is a read of the maximum or minimum and the load of its result register, which happens in the cycle right after a new operand is captured. The bench writes an operand and reads the result on the very next cycle. It expects the stale value there, and the new one a cycle later. The second is a write and a read in the same cycle. The bench raises both strobes together with one code. It expects 0x00 for a write code and then confirms that the write took effect, and it expects the unchanged result for a read code.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  typedef enum logic [3:0] {
    SEL_MUL_A  = 4'd0,  SEL_MUL_B  = 4'd1,  SEL_MUL_LO = 4'd2,  SEL_MUL_HI = 4'd3,
    SEL_DIV_N  = 4'd4,  SEL_DIV_D  = 4'd5,  SEL_DIV_Q  = 4'd6,  SEL_DIV_R  = 4'd7,
    SEL_RSV0   = 4'd8,  SEL_MAX_A  = 4'd9,  SEL_MAX_B  = 4'd10, SEL_MAX_Y  = 4'd11,
    SEL_RSV1   = 4'd12, SEL_MIN_A  = 4'd13, SEL_MIN_B  = 4'd14, SEL_MIN_Y  = 4'd15
  } sel_e;

  typedef struct packed {
    logic mul_a;
    logic mul_b;
    logic div_n;
    logic div_d;
    logic max_a;
    logic max_b;
    logic min_a;
    logic min_b;
  } wstb_t;
endpackage

// File: rtl/fcp_decode.sv
module fcp_decode
  import fcp_pkg::*;
(
  input  logic [3:0] sel,
  input  logic       wr_en,
  output wstb_t      wstb
);
  always_comb begin
    wstb = '0;
    if (wr_en) begin
      case (sel)
        SEL_MUL_A: wstb.mul_a = 1'b1;
        SEL_MUL_B: wstb.mul_b = 1'b1;
        SEL_DIV_N: wstb.div_n = 1'b1;
        SEL_DIV_D: wstb.div_d = 1'b1;
        SEL_MAX_A: wstb.max_a = 1'b1;
        SEL_MAX_B: wstb.max_b = 1'b1;
        SEL_MIN_A: wstb.min_a = 1'b1;
        SEL_MIN_B: wstb.min_b = 1'b1;
        default:   wstb = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcp_arith.sv
module fcp_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   mul_a,
  input  logic [DW-1:0]   mul_b,
  input  logic [DW-1:0]   div_n,
  input  logic [DW-1:0]   div_d,
  output logic [2*DW-1:0] prod,
  output logic [DW-1:0]   quo,
  output logic [DW-1:0]   rem
);
  localparam int PW = 2 * DW;

  assign prod = PW'(mul_a) * PW'(mul_b);

  always_comb begin
    if (div_d == '0) begin
      quo = '1;
      rem = div_n;
    end else begin
      quo = div_n / div_d;
      rem = div_n % div_d;
    end
  end
endmodule

// File: rtl/fcp_lattice.sv
module fcp_lattice #(
  parameter int DW       = 8,
  parameter bit PICK_MAX = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic          we_b,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] y
);
  logic [DW-1:0] op_a, op_b, pick;
  logic          a_wins;

  generate
    if (PICK_MAX) begin : g_max
      assign a_wins = (op_a > op_b);
    end else begin : g_min
      assign a_wins = (op_a < op_b);
    end
  endgenerate

  assign pick = a_wins ? op_a : op_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_a <= '0;
      op_b <= '0;
      y    <= '0;
    end else begin
      if (we_a) op_a <= wdata;
      if (we_b) op_b <= wdata;
      y <= pick;
    end
  end
endmodule

// File: rtl/fuzzy_coproc.sv
module fuzzy_coproc
  import fcp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int PW = 2 * DW;

  wstb_t         wstb;
  logic [DW-1:0] mul_a, mul_b, div_n, div_d;
  logic [PW-1:0] prod;
  logic [DW-1:0] quo, rem, max_y, min_y;

  fcp_decode u_dec (.sel(sel), .wr_en(wr_en), .wstb(wstb));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mul_a <= '0;
      mul_b <= '0;
      div_n <= '0;
      div_d <= '0;
    end else begin
      if (wstb.mul_a) mul_a <= wdata;
      if (wstb.mul_b) mul_b <= wdata;
      if (wstb.div_n) div_n <= wdata;
      if (wstb.div_d) div_d <= wdata;
    end
  end

  fcp_arith #(.DW(DW)) u_arith (
    .mul_a(mul_a), .mul_b(mul_b), .div_n(div_n), .div_d(div_d),
    .prod(prod), .quo(quo), .rem(rem)
  );

  fcp_lattice #(.DW(DW), .PICK_MAX(1'b1)) u_max (
    .clk(clk), .rst_n(rst_n), .we_a(wstb.max_a), .we_b(wstb.max_b),
    .wdata(wdata), .y(max_y)
  );

  fcp_lattice #(.DW(DW), .PICK_MAX(1'b0)) u_min (
    .clk(clk), .rst_n(rst_n), .we_a(wstb.min_a), .we_b(wstb.min_b),
    .wdata(wdata), .y(min_y)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_MUL_LO: rdata = prod[DW-1:0];
        SEL_MUL_HI: rdata = prod[PW-1:DW];
        SEL_DIV_Q:  rdata = quo;
        SEL_DIV_R:  rdata = rem;
        SEL_MAX_Y:  rdata = max_y;
        SEL_MIN_Y:  rdata = min_y;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcp_checker.sv
module fcp_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    sel,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata
);
  localparam int PW = 2 * DW;

  logic [DW-1:0] s_ma, s_mb, s_dn, s_dd, s_xa, s_xb, s_xy, s_na, s_nb, s_ny;
  logic [PW-1:0] s_prod;
  logic          rd_wcode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ma <= '0; s_mb <= '0; s_dn <= '0; s_dd <= '0;
      s_xa <= '0; s_xb <= '0; s_xy <= '0;
      s_na <= '0; s_nb <= '0; s_ny <= '0;
    end else begin
      if (wr_en && sel == 4'd0)  s_ma <= wdata;
      if (wr_en && sel == 4'd1)  s_mb <= wdata;
      if (wr_en && sel == 4'd4)  s_dn <= wdata;
      if (wr_en && sel == 4'd5)  s_dd <= wdata;
      if (wr_en && sel == 4'd9)  s_xa <= wdata;
      if (wr_en && sel == 4'd10) s_xb <= wdata;
      if (wr_en && sel == 4'd13) s_na <= wdata;
      if (wr_en && sel == 4'd14) s_nb <= wdata;
      s_xy <= (s_xa >= s_xb) ? s_xa : s_xb;
      s_ny <= (s_na <= s_nb) ? s_na : s_nb;
    end
  end

  assign s_prod   = PW'(s_ma) * PW'(s_mb);
  assign rd_wcode = rd_en && (sel == 4'd0 || sel == 4'd1 || sel == 4'd4 || sel == 4'd5 ||
                              sel == 4'd9 || sel == 4'd10 || sel == 4'd13 || sel == 4'd14);

  AST_MUL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == 4'd2) |-> rdata == s_prod[DW-1:0]);  // R2
  AST_MUL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == 4'd3) |-> rdata == s_prod[PW-1:DW]);  // R2
  AST_DIV_ZERO_QUO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == 4'd6 && s_dd == '0) |-> rdata == '1);  // R4
  AST_DIV_ZERO_REM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == 4'd7 && s_dd == '0) |-> rdata == s_dn);  // R4
  AST_MAX_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == 4'd11) |-> rdata == s_xy);  // R5
  AST_MIN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == 4'd15) |-> rdata == s_ny);  // R6
  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel == 4'd8 || sel == 4'd12)) |-> rdata == '0);  // R7
  AST_WCODE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wcode |-> rdata == '0);  // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);  // R9
endmodule

bind fuzzy_coproc fcp_checker #(.DW(DW)) u_chk (.*);

// File: tb/fuzzy_coproc_bench.sv
module fuzzy_coproc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       chk = 1'b0;
  logic       done = 1'b0;
  int         n_cmp = 0;
  int         n_bad = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  fuzzy_coproc u_fuzzy_coproc (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  task automatic step(input logic [3:0] s, input logic w, input logic r,
                      input logic [7:0] d, input logic c, input logic [7:0] e, input string t);
    @(posedge clk);
    #2;
    sel = s; wr_en = w; rd_en = r; wdata = d; chk = c;
    if (c) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    step(s, 1'b1, 1'b0, d, 1'b0, 8'h00, "");
  endtask

  task automatic rd(input logic [3:0] s, input logic [7:0] e, input string t);
    step(s, 1'b0, 1'b1, 8'h00, 1'b1, e, t);
  endtask

  // monitor: pops the scoreboard in mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (chk && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", t, sel, rdata, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd(4'd2, 8'h00, "R1 prod lo");
    rd(4'd3, 8'h00, "R1 prod hi");
    rd(4'd6, 8'hFF, "R1 quotient");
    rd(4'd7, 8'h00, "R1 remainder");
    rd(4'd11, 8'h00, "R1 max");
    rd(4'd15, 8'h00, "R1 min");
    // R9 idle output
    step(4'd2, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, "R9 idle");
    // R2 multiply
    wr(4'd0, 8'hC8); wr(4'd1, 8'h0F);
    rd(4'd2, 8'hB8, "R2 lo 200*15");
    rd(4'd3, 8'h0B, "R2 hi 200*15");
    wr(4'd0, 8'hFF); wr(4'd1, 8'hFF);
    rd(4'd2, 8'h01, "R2 lo 255*255");
    rd(4'd3, 8'hFE, "R2 hi 255*255");
    // R3 divide
    wr(4'd4, 8'd200); wr(4'd5, 8'd7);
    rd(4'd6, 8'd28, "R3 quotient 200/7");
    rd(4'd7, 8'd4, "R3 remainder 200/7");
    // R4 divide by zero
    wr(4'd5, 8'd0);
    rd(4'd6, 8'hFF, "R4 quotient div0");
    rd(4'd7, 8'hC8, "R4 remainder div0");
    // R5 maximum with one-cycle lag
    wr(4'd9, 8'h30); wr(4'd10, 8'h90);
    rd(4'd11, 8'h30, "R5 max stale");
    rd(4'd11, 8'h90, "R5 max settled");
    wr(4'd10, 8'h10);
    rd(4'd11, 8'h90, "R5 max stale after lower");
    rd(4'd11, 8'h30, "R5 max settled after lower");
    // R6 minimum with one-cycle lag
    wr(4'd13, 8'h40); wr(4'd14, 8'h22);
    rd(4'd15, 8'h00, "R6 min stale");
    rd(4'd15, 8'h22, "R6 min settled");
    // R7 unused codes
    wr(4'd8, 8'h55); wr(4'd12, 8'h66);
    step(4'd0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "");
    rd(4'd2, 8'h01, "R7 prod lo unchanged");
    rd(4'd3, 8'hFE, "R7 prod hi unchanged");
    rd(4'd11, 8'h30, "R7 max unchanged");
    rd(4'd15, 8'h22, "R7 min unchanged");
    rd(4'd6, 8'hFF, "R7 quotient unchanged");
    rd(4'd8, 8'h00, "R7 read code 8");
    rd(4'd12, 8'h00, "R7 read code 12");
    // R8 strobe/code mismatch, both strobes in one cycle
    step(4'd2, 1'b1, 1'b1, 8'h77, 1'b1, 8'h01, "R8 write to read code ignored");
    rd(4'd2, 8'h01, "R8 prod lo after ignored write");
    step(4'd0, 1'b1, 1'b1, 8'h05, 1'b1, 8'h00, "R8 read of write code");
    rd(4'd2, 8'hFB, "R8 write took effect lo");
    rd(4'd3, 8'h04, "R8 write took effect hi");
    rd(4'd9, 8'h00, "R8 read code 9");
    rd(4'd14, 8'h00, "R8 read code 14");
    step(4'd0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule